// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Unit with Rounded Store

This block is the arithmetic core of a fixed-point signal-processing datapath. Each clock it can take two signed fractional operands, form their full-precision product, and clear, load, add into or subtract from a wide accumulator. The accumulator carries guard bits above the product field, so long sums of products do not wrap.

The accumulator drives a rounding and saturation stage without any register in between. That stage yields the single-precision word that would be written back to memory. The caller picks one of the rounding behaviours on every cycle. Results too large for the word clamp to the nearest extreme value and do not wrap. An overflow flag reports the clamp and stays set until the accumulator is cleared. Operands use Q1.23 format (sign bit, then the radix point). The product is realigned to Q1.47 by dropping its redundant sign bit.

Top module: `fxp_mac_round`

## Requirements
- R1: After a synchronous reset, `acc_o` is 0, `word_o` is 0 and `ovf_o` is 0.
- R2: With `valid_i` high and `op_i`=1 (load), the accumulator takes the value 2·a·b as a 56-bit signed integer (a and b are the signed operand codes), visible on `acc_o` after that clock edge.
- R3: When both operands are -1.0 (0x800000), the product clamps to the most positive 48-bit value 2^47-1. It does not become +1.0.
- R4: `op_i`=2 adds the product to the accumulator and `op_i`=3 subtracts it. Each operation completes in the single clock edge on which it is issued.
- R5: While `valid_i` is low, the accumulator keeps its value whatever `op_i`, `a_i` and `b_i` hold.
- R6: With `valid_i` high and `op_i`=0 (clear), the accumulator becomes 0 and `ovf_o` drops, both after that edge.
- R7: `rnd_i`=0 (truncate) gives `word_o` = floor(acc / 2^24), that is, the low 24 bits are dropped.
- R8: `rnd_i`=1 (nearest) adds one to the kept word when the low 24 bits are at least 0x800000.
- R9: `rnd_i`=2 (convergent) rounds up above one half and down below one half. At exactly one half it rounds so that the kept LSB is zero.
- R10: When the rounded value lies outside [-2^23, 2^23-1], `word_o` is 0x7FFFFF or 0x800000 according to its sign, and `ovf_o` is high in the same cycle.
- R11: Once `ovf_o` has been high across a clock edge, it stays high until a clear, even after the accumulator returns to range.
- R12: `rnd_i`=3 behaves exactly like truncate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Issue strobe for `op_i` |
| op_i | input | 2 | 0 clear, 1 load, 2 accumulate, 3 subtract |
| rnd_i | input | 2 | 0 truncate, 1 nearest, 2 convergent, 3 truncate |
| a_i | input | 24 | Signed Q1.23 operand |
| b_i | input | 24 | Signed Q1.23 operand |
| acc_o | output | 56 | Accumulator: 8 guard bits over a Q1.47 field |
| word_o | output | 24 | Rounded, saturated Q1.23 store word |
| ovf_o | output | 1 | Saturation flag, sticky until clear |

## Verification
A wrong accumulator value appears on `acc_o` one edge after the operation that caused it. Through the combinational store path it also reaches `word_o` in that same cycle, so the bench compares both ports after every issued operation. A fault in the rounding stage leaves `acc_o` correct and shows only on `word_o`. For that reason every rounding code is swept without a clock edge, on accumulator values whose low half sits just below, exactly at and just above one half, with both even and odd kept LSBs. A sticky-flag fault shows only after the accumulator has come back into range, which the bench sets up on purpose.

// File: rtl/fxp_mac_pkg.sv
package fxp_mac_pkg;
   typedef enum logic [1:0] {
      OP_CLR  = 2'd0,
      OP_LOAD = 2'd1,
      OP_ADD  = 2'd2,
      OP_SUB  = 2'd3
   } mac_op_e;

   typedef enum logic [1:0] {
      RND_TRUNC = 2'd0,
      RND_NEAR  = 2'd1,
      RND_CONV  = 2'd2,
      RND_ALT   = 2'd3
   } mac_rnd_e;
endpackage

// File: rtl/fxp_mac_mul.sv
module fxp_mac_mul #(
   parameter int DATA_W     = 24,
   parameter bit FRAC_ALIGN = 1'b1
) (
   input  logic [DATA_W-1:0]   a_i,
   input  logic [DATA_W-1:0]   b_i,
   output logic [2*DATA_W-1:0] prod_o
);
   localparam int PROD_W = 2 * DATA_W;
   localparam logic [DATA_W-1:0] MIN_OPND = {1'b1, {(DATA_W-1){1'b0}}};
   localparam logic [PROD_W-1:0] MAX_PROD = {1'b0, {(PROD_W-1){1'b1}}};

   logic signed [PROD_W-1:0] full;
   assign full = PROD_W'($signed(a_i)) * PROD_W'($signed(b_i));

   generate
      if (FRAC_ALIGN) begin : g_frac
         logic [PROD_W-1:0] shifted;
         logic              both_min;
         assign shifted  = full << 1;
         assign both_min = (a_i == MIN_OPND) && (b_i == MIN_OPND);
         assign prod_o   = both_min ? MAX_PROD : shifted;
      end else begin : g_int
         assign prod_o = full;
      end
   endgenerate
endmodule

// File: rtl/fxp_mac_acc.sv
module fxp_mac_acc
   import fxp_mac_pkg::*;
#(
   parameter int PROD_W  = 48,
   parameter int GUARD_W = 8
) (
   input  logic                      clk_i,
   input  logic                      rst_i,
   input  logic                      valid_i,
   input  mac_op_e                   op_i,
   input  logic [PROD_W-1:0]         prod_i,
   output logic [PROD_W+GUARD_W-1:0] acc_o
);
   localparam int ACC_W = PROD_W + GUARD_W;

   logic [ACC_W-1:0] prod_ext;
   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] acc_d;

   assign prod_ext = {{GUARD_W{prod_i[PROD_W-1]}}, prod_i};

   always_comb begin
      acc_d = acc_q;
      if (valid_i) begin
         unique case (op_i)
            OP_CLR:  acc_d = '0;
            OP_LOAD: acc_d = prod_ext;
            OP_ADD:  acc_d = acc_q + prod_ext;
            OP_SUB:  acc_d = acc_q - prod_ext;
            default: acc_d = acc_q;
         endcase
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) acc_q <= '0;
      else       acc_q <= acc_d;
   end

   assign acc_o = acc_q;
endmodule

// File: rtl/fxp_mac_store.sv
module fxp_mac_store
   import fxp_mac_pkg::*;
#(
   parameter int DATA_W = 24,
   parameter int ACC_W  = 56
) (
   input  logic [ACC_W-1:0]  acc_i,
   input  mac_rnd_e          rnd_i,
   output logic [DATA_W-1:0] word_o,
   output logic              sat_o
);
   localparam int HI_W  = ACC_W - DATA_W;
   localparam int CHK_W = HI_W - DATA_W + 2;
   localparam logic [DATA_W-1:0] MAX_W = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic [DATA_W-1:0] MIN_W = {1'b1, {(DATA_W-1){1'b0}}};

   logic [HI_W-1:0]   hi;
   logic [DATA_W-1:0] lo;
   logic              half_bit;
   logic              tail_nz;
   logic              inc;
   logic [HI_W:0]     sum;
   logic [CHK_W-1:0]  top_bits;
   logic              fits;

   assign hi       = acc_i[ACC_W-1:DATA_W];
   assign lo       = acc_i[DATA_W-1:0];
   assign half_bit = lo[DATA_W-1];
   assign tail_nz  = |lo[DATA_W-2:0];

   always_comb begin
      unique case (rnd_i)
         RND_NEAR: inc = half_bit;
         RND_CONV: inc = half_bit & (tail_nz | hi[0]);
         default:  inc = 1'b0;
      endcase
   end

   assign sum      = {hi[HI_W-1], hi} + {{HI_W{1'b0}}, inc};
   assign top_bits = sum[HI_W:DATA_W-1];
   assign fits     = (top_bits == '0) || (top_bits == '1);
   assign sat_o    = ~fits;
   assign word_o   = fits ? sum[DATA_W-1:0] : (sum[HI_W] ? MIN_W : MAX_W);
endmodule

// File: rtl/fxp_mac_round.sv
module fxp_mac_round
   import fxp_mac_pkg::*;
#(
   parameter int DATA_W  = 24,
   parameter int GUARD_W = 8
) (
   input  logic                           clk_i,
   input  logic                           rst_i,
   input  logic                           valid_i,
   input  logic [1:0]                     op_i,
   input  logic [1:0]                     rnd_i,
   input  logic [DATA_W-1:0]              a_i,
   input  logic [DATA_W-1:0]              b_i,
   output logic [2*DATA_W+GUARD_W-1:0]    acc_o,
   output logic [DATA_W-1:0]              word_o,
   output logic                           ovf_o
);
   localparam int PROD_W = 2 * DATA_W;
   localparam int ACC_W  = PROD_W + GUARD_W;

   generate
      if (DATA_W < 4 || GUARD_W < 1) begin : g_bad_param
         initial $fatal(1, "fxp_mac_round: DATA_W must be >= 4 and GUARD_W >= 1");
      end
   endgenerate

   mac_op_e           op;
   mac_rnd_e          rnd;
   logic [PROD_W-1:0] prod;
   logic [ACC_W-1:0]  acc;
   logic              sat_now;
   logic              sticky_q;

   assign op  = mac_op_e'(op_i);
   assign rnd = mac_rnd_e'(rnd_i);

   fxp_mac_mul #(.DATA_W(DATA_W), .FRAC_ALIGN(1'b1)) u_mul (
      .a_i    (a_i),
      .b_i    (b_i),
      .prod_o (prod)
   );

   fxp_mac_acc #(.PROD_W(PROD_W), .GUARD_W(GUARD_W)) u_acc (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .valid_i (valid_i),
      .op_i    (op),
      .prod_i  (prod),
      .acc_o   (acc)
   );

   fxp_mac_store #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_store (
      .acc_i  (acc),
      .rnd_i  (rnd),
      .word_o (word_o),
      .sat_o  (sat_now)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i)                          sticky_q <= 1'b0;
      else if (valid_i && op == OP_CLR)   sticky_q <= 1'b0;
      else if (sat_now)                   sticky_q <= 1'b1;
   end

   assign acc_o = acc;
   assign ovf_o = sticky_q | sat_now;
endmodule

// File: rtl/fxp_mac_round_chk.sv
module fxp_mac_round_chk #(
   parameter int DATA_W  = 24,
   parameter int GUARD_W = 8
) (
   input logic                        clk_i,
   input logic                        rst_i,
   input logic                        valid_i,
   input logic [1:0]                  op_i,
   input logic [DATA_W-1:0]           a_i,
   input logic [DATA_W-1:0]           b_i,
   input logic [2*DATA_W+GUARD_W-1:0] acc_o,
   input logic [DATA_W-1:0]           word_o,
   input logic                        ovf_o
);
   localparam int ACC_W = 2 * DATA_W + GUARD_W;

   assert_reset_state_R1: assert property (@(posedge clk_i)
      rst_i |=> (acc_o == '0) && !ovf_o);

   assert_zero_operand_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      (valid_i && op_i == 2'd1 && (a_i == '0 || b_i == '0)) |=> (acc_o == '0));

   assert_hold_idle_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      !valid_i |=> $stable(acc_o));

   assert_clear_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      (valid_i && op_i == 2'd0) |=> (acc_o == '0) && !ovf_o && (word_o == '0));

   assert_sign_kept_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      !acc_o[ACC_W-1] |-> !word_o[DATA_W-1]);

   assert_flag_sticky_R11: assert property (@(posedge clk_i) disable iff (rst_i)
      (ovf_o && !(valid_i && op_i == 2'd0)) |=> ovf_o);
endmodule

bind fxp_mac_round fxp_mac_round_chk #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_chk (
   .clk_i   (clk_i),
   .rst_i   (rst_i),
   .valid_i (valid_i),
   .op_i    (op_i),
   .a_i     (a_i),
   .b_i     (b_i),
   .acc_o   (acc_o),
   .word_o  (word_o),
   .ovf_o   (ovf_o)
);

// File: tb/fxp_mac_round_tb.sv
`timescale 1ns/100ps
module fxp_mac_round_tb_top;
   logic        clk_i = 1'b0;
   logic        rst_i = 1'b1;
   logic        valid_i = 1'b0;
   logic [1:0]  op_i = 2'd0;
   logic [1:0]  rnd_i = 2'd0;
   logic [23:0] a_i = '0;
   logic [23:0] b_i = '0;
   logic [55:0] acc_o;
   logic [23:0] word_o;
   logic        ovf_o;

   int    n_checks = 0;
   int    n_errors = 0;
   longint ref_acc = 0;
   bit    ref_sticky = 1'b0;
   logic [1:0] cur_mode = 2'd0;

   always #2.5 clk_i = ~clk_i;

   fxp_mac_round dut_i (
      .clk_i (clk_i), .rst_i (rst_i), .valid_i (valid_i), .op_i (op_i),
      .rnd_i (rnd_i), .a_i (a_i), .b_i (b_i), .acc_o (acc_o),
      .word_o (word_o), .ovf_o (ovf_o)
   );

   function automatic longint ref_prod(longint a, longint b);
      if (a == -(64'sd1 <<< 23) && b == -(64'sd1 <<< 23)) return (64'sd1 <<< 47) - 1;
      return 2 * a * b;
   endfunction

   function automatic longint ref_round(longint acc, logic [1:0] m);
      longint hi, lo, inc;
      hi  = acc >>> 24;
      lo  = acc & 64'hFF_FFFF;
      inc = 0;
      if (m == 2'd1 && lo >= 64'h80_0000) inc = 1;
      if (m == 2'd2 && (lo > 64'h80_0000 || (lo == 64'h80_0000 && hi[0]))) inc = 1;
      return hi + inc;
   endfunction

   function automatic bit ref_sat(longint acc, logic [1:0] m);
      longint r;
      r = ref_round(acc, m);
      return (r > 64'sd8388607) || (r < -64'sd8388608);
   endfunction

   function automatic longint ref_word(longint acc, logic [1:0] m);
      longint r;
      r = ref_round(acc, m);
      if (r > 64'sd8388607) return 64'sd8388607;
      if (r < -64'sd8388608) return -64'sd8388608;
      return r;
   endfunction

   task automatic check(string tag, longint act, longint exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic check_state(string tag);
      check({tag, " acc"}, longint'($signed(acc_o)), ref_acc);
      check({tag, " word"}, longint'($signed(word_o)), ref_word(ref_acc, cur_mode));
      check({tag, " ovf"}, longint'(ovf_o), longint'(ref_sticky | ref_sat(ref_acc, cur_mode)));
   endtask

   // drives one clock edge; model follows the requirements
   task automatic step(bit v, logic [1:0] op, longint a, longint b);
      @(negedge clk_i);
      valid_i = v; op_i = op; a_i = a[23:0]; b_i = b[23:0]; rnd_i = cur_mode;
      @(posedge clk_i);
      if (v && op == 2'd0) ref_sticky = 1'b0;
      else ref_sticky = ref_sticky | ref_sat(ref_acc, cur_mode);
      if (v) begin
         case (op)
            2'd0: ref_acc = 0;
            2'd1: ref_acc = ref_prod(a, b);
            2'd2: ref_acc = ref_acc + ref_prod(a, b);
            default: ref_acc = ref_acc - ref_prod(a, b);
         endcase
      end
      @(negedge clk_i);
      valid_i = 1'b0;
      #0.2;
   endtask

   // all rounding codes on the held accumulator, no clock edge in between
   task automatic sweep_modes(string tag);
      for (int m = 0; m < 4; m++) begin
         string rq;
         rq = (m == 0) ? "R7" : (m == 1) ? "R8" : (m == 2) ? "R9" : "R12";
         rnd_i = m[1:0];
         #0.4;
         check({tag, " ", rq, " word"}, longint'($signed(word_o)), ref_word(ref_acc, m[1:0]));
         check({tag, " R10 ovf"}, longint'(ovf_o),
               longint'(ref_sticky | ref_sat(ref_acc, m[1:0])));
      end
      rnd_i = cur_mode;
   endtask

   task automatic t_reset();
      check("R1 acc", longint'($signed(acc_o)), 0);
      check("R1 word", longint'($signed(word_o)), 0);
      check("R1 ovf", longint'(ovf_o), 0);
   endtask

   task automatic t_load();
      step(1, 2'd1, 24'sd3, 24'sd5);                check_state("R2 load small");
      step(1, 2'd1, -64'sd4194304, 64'sd4194304);   check_state("R2 load -0.5*0.5");
      step(1, 2'd1, -64'sd8388608, 64'sd8388607);   check_state("R2 load min*max");
      step(1, 2'd1, -64'sd8388608, -64'sd8388608);  check_state("R3 min*min");
      check("R3 acc value", longint'($signed(acc_o)), (64'sd1 <<< 47) - 1);
   endtask

   task automatic t_accum();
      step(1, 2'd1, 64'sd1000, 64'sd2000);   check_state("R4 load");
      step(1, 2'd2, 64'sd3000, -64'sd70);    check_state("R4 add");
      step(1, 2'd3, -64'sd123456, 64'sd789); check_state("R4 sub");
      step(0, 2'd1, 64'sd5555, 64'sd7777);   check_state("R5 idle load");
      step(0, 2'd0, 64'sd1, 64'sd1);         check_state("R5 idle clear");
   endtask

   task automatic t_rounding();
      // exactly half, kept LSB even / odd, both signs
      step(1, 2'd1, 64'sd2048, 64'sd2048);   sweep_modes("half even");
      step(1, 2'd1, 64'sd6144, 64'sd2048);   sweep_modes("half odd");
      step(1, 2'd1, -64'sd2048, 64'sd2048);  sweep_modes("neg half");
      step(1, 2'd3, 64'sd1, 64'sd1);         sweep_modes("just below half");
      step(1, 2'd2, 64'sd1, 64'sd2);         sweep_modes("just above half");
      step(1, 2'd1, -64'sd1, 64'sd1);        sweep_modes("tiny negative");
      step(1, 2'd1, 64'sd8388607, 64'sd8388607); sweep_modes("near max");
   endtask

   task automatic t_saturate();
      step(1, 2'd0, 0, 0);                          check_state("R6 clear");
      step(1, 2'd1, 64'sd8388607, 64'sd8388607);
      step(1, 2'd2, 64'sd8388607, 64'sd8388607);    check_state("R10 pos sat");
      check("R10 pos word", longint'($signed(word_o)), 64'sd8388607);
      sweep_modes("pos sat");
      step(1, 2'd3, 64'sd8388607, 64'sd8388607);    check_state("R11 back in range");
      check("R11 flag held", longint'(ovf_o), 1);
      step(0, 2'd2, 0, 0);                          check("R11 flag idle", longint'(ovf_o), 1);
      step(1, 2'd0, 0, 0);                          check_state("R6 clear drops flag");
      check("R6 flag low", longint'(ovf_o), 0);
      step(1, 2'd1, -64'sd8388607, 64'sd8388607);
      step(1, 2'd3, 64'sd8388607, 64'sd8388607);    check_state("R10 neg sat");
      check("R10 neg word", longint'($signed(word_o)), -64'sd8388608);
      step(1, 2'd0, 0, 0);                          check_state("R6 clear after neg");
   endtask

   task automatic t_mixed();
      logic [31:0] lfsr;
      lfsr = 32'hACE1_2357;
      for (int i = 0; i < 40; i++) begin
         longint a, b;
         logic [1:0] op;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         a = longint'($signed(lfsr[23:0]));
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         b = longint'($signed(lfsr[23:0]));
         op = (lfsr[26:24] == 3'd0) ? 2'd0 : (lfsr[25:24] == 2'd0 ? 2'd1 : lfsr[25:24]);
         cur_mode = lfsr[29:28];
         step(lfsr[30] | lfsr[31], op, a, b);
         check_state("R4 mixed");
         if (i % 8 == 0) sweep_modes("mixed");
      end
      cur_mode = 2'd0;
   endtask

   initial begin
      #(200000 * 5);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk_i);
      @(negedge clk_i);
      rst_i = 1'b0;
      #0.2;
      t_reset();
      t_load();
      t_accum();
      t_rounding();
      t_saturate();
      t_mixed();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule